// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block takes in a single-line synchronous bit stream, one bit per receive clock, and turns it into parallel words. A start pulse opens a frame. The receiver then collects a programmed number of words, each with a programmed number of bits, and returns to idle to wait for the next start. The bits may arrive most-significant first or least-significant first. Every finished word is placed right-aligned on a 32-bit output together with a one-cycle valid strobe. The last word of a frame also raises a frame-done strobe.

Each accepted start also launches a locally generated frame-sync pulse of programmable length. A loopback selector switches the data line, the start line and the receive clock over to the local transmitter's data, frame-sync and clock, so the path can be tested without external wiring. A transfer-size code tells a downstream DMA engine how wide each word is: byte, halfword or word. The code is worked out from the configured length. A zero length setting is illegal. A start under that setting is refused and flagged.

Top module: `rxs_frame_rx`

## Requirements
- R1: Each word has cfg_len+1 bits, with cfg_len a 5-bit field. The cycle after the edge that samples a word's last bit shows the word on word_data with word_valid high for exactly one cycle. The first data bit is sampled on the edge after the one that accepts the start, and the bits of a frame follow each other with no gaps.
- R2: With cfg_msb_first=1, the first bit received ends up at bit cfg_len of word_data, and later bits fill the lower positions in turn. All bits above cfg_len read 0.
- R3: With cfg_msb_first=0, the first bit received ends up at bit 0, and later bits fill the higher positions in turn. All bits above cfg_len read 0.
- R4: A frame holds cfg_words+1 words, with cfg_words a 4-bit field. frame_done pulses together with the word_valid of the last word. busy is low from the following cycle.
- R5: After an accepted start, sync_out is high for cfg_sync_len+1 cycles (4-bit field), beginning in the cycle after the accepting edge.
- R6: If a start arrives while cfg_len is 0, no reception begins, busy stays low and cfg_error goes high. The next accepted start clears cfg_error.
- R7: A start that arrives while a frame is in progress is ignored. The frame's words come out unchanged.
- R8: xfer_size is 0 when cfg_len is 0, 1 (byte) for 1 to 7, 2 (halfword) for 8 to 15, and 3 (word) for 16 to 31.
- R9: When cfg_loop=1, data, start and clock are taken from lb_data, lb_fs and lb_clk. ext_data and ext_start have no effect. When cfg_loop=0, the ext_* pins are used and the lb_* data and start pins have no effect.
- R10: While rst is high, word_valid, frame_done, busy, sync_out and cfg_error are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ext_clk | input | 1 | External receive clock |
| lb_clk | input | 1 | Local transmit clock, used in loopback |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loop | input | 1 | 1 selects the loopback sources |
| ext_data | input | 1 | External serial data |
| ext_start | input | 1 | External start pulse |
| lb_data | input | 1 | Local transmit data |
| lb_fs | input | 1 | Local transmit frame sync, used as start in loopback |
| cfg_len | input | 5 | Bits per word minus one (0 is illegal) |
| cfg_words | input | 4 | Words per frame minus one |
| cfg_sync_len | input | 4 | Sync pulse length minus one |
| cfg_msb_first | input | 1 | 1: first bit is the word's MSB |
| word_data | output | 32 | Right-aligned received word |
| word_valid | output | 1 | One-cycle strobe, word_data is valid |
| frame_done | output | 1 | One-cycle strobe on the last word of a frame |
| busy | output | 1 | A frame is in progress |
| sync_out | output | 1 | Generated frame-sync pulse |
| cfg_error | output | 1 | A start was refused because cfg_len was 0 |
| xfer_size | output | 2 | Transfer-size code derived from cfg_len |

## Verification
The hardest case to reach from the ports is a start arriving in the middle of a frame. This includes a start that lands exactly on the edge that samples a word's last bit, where the frame state is about to change. The driver raises the start line on a chosen bit index inside a running multi-word frame. The scoreboard then requires the same words and a single frame-done as an undisturbed frame. Sync pulses longer than a whole frame, and loopback with the external pins held at the complement of the real stream, are driven in the same way.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int LEN_W  = 5;
    localparam int DW     = 1 << LEN_W;
    localparam int CNT_W  = 4;
    localparam int SYNC_W = 4;

    typedef enum logic [1:0] {
        XS_NONE = 2'd0,
        XS_BYTE = 2'd1,
        XS_HALF = 2'd2,
        XS_WORD = 2'd3
    } xfer_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] words;
        logic             msb;
    } frame_cfg_t;

    function automatic xfer_e xfer_of(input logic [LEN_W-1:0] len);
        if (len == '0)
            return XS_NONE;
        else if (len < LEN_W'(8))
            return XS_BYTE;
        else if (len < LEN_W'(16))
            return XS_HALF;
        else
            return XS_WORD;
    endfunction
endpackage

// File: rtl/rxs_src_sel.sv
module rxs_src_sel (
    input  logic cfg_loop,
    input  logic ext_clk,
    input  logic lb_clk,
    input  logic ext_data,
    input  logic lb_data,
    input  logic ext_start,
    input  logic lb_fs,
    output logic rx_clk,
    output logic rx_data,
    output logic rx_start
);
    // loopback swaps all three receive sources at once
    assign rx_clk   = cfg_loop ? lb_clk  : ext_clk;
    assign rx_data  = cfg_loop ? lb_data : ext_data;
    assign rx_start = cfg_loop ? lb_fs   : ext_start;
endmodule

// File: rtl/rxs_sync_gen.sv
module rxs_sync_gen #(
    parameter int SYNC_W = rxs_pkg::SYNC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [SYNC_W-1:0] sync_len,
    output logic              sync_out
);
    logic [SYNC_W-1:0] remain;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (trig) begin
            active <= 1'b1;
            remain <= sync_len;
        end else if (active) begin
            if (remain == '0)
                active <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    assign sync_out = active;

    // R5
    fs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> sync_out);

    // R5
    fs_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_out && remain == '0 && !trig) |=> !sync_out);
endmodule

// File: rtl/rxs_deser.sv
module rxs_deser
    import rxs_pkg::*;
#(
    parameter int DW    = rxs_pkg::DW,
    parameter int LEN_W = rxs_pkg::LEN_W,
    parameter int CNT_W = rxs_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic          start,
    input  frame_cfg_t    cfg_in,
    output logic [DW-1:0] word_data,
    output logic          word_valid,
    output logic          frame_done,
    output logic          busy,
    output logic          cfg_error,
    output logic          accept
);
    rx_state_e        state;
    frame_cfg_t       cfg_q;
    logic [LEN_W-1:0] bit_cnt;
    logic [CNT_W-1:0] word_cnt;
    logic [DW-1:0]    acc;
    logic [DW-1:0]    acc_base;
    logic [DW-1:0]    acc_next;
    logic             last_bit;
    logic             last_word;

    assign accept    = (state == ST_IDLE) && start && (cfg_in.len != '0);
    assign last_bit  = (bit_cnt == cfg_q.len);
    assign last_word = (word_cnt == cfg_q.words);
    assign busy      = (state == ST_RUN);

    always_comb begin
        acc_base = (bit_cnt == '0) ? '0 : acc;
        if (cfg_q.msb)
            acc_next = {acc_base[DW-2:0], din};
        else
            acc_next = acc_base | (DW'(din) << bit_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            bit_cnt    <= '0;
            word_cnt   <= '0;
            acc        <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
            frame_done <= 1'b0;
            cfg_error  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_in.len == '0) begin
                            cfg_error <= 1'b1;
                        end else begin
                            cfg_error <= 1'b0;
                            cfg_q     <= cfg_in;
                            bit_cnt   <= '0;
                            word_cnt  <= '0;
                            state     <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    acc <= acc_next;
                    if (last_bit) begin
                        word_data  <= acc_next;
                        word_valid <= 1'b1;
                        bit_cnt    <= '0;
                        if (last_word) begin
                            frame_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            word_cnt <= word_cnt + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R4
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (word_valid && state == ST_IDLE));

    // R6
    len_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && cfg_in.len == '0) |=> (state == ST_IDLE && cfg_error));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !(last_bit && last_word)) |=> (state == ST_RUN));
endmodule

// File: rtl/rxs_frame_rx.sv
module rxs_frame_rx
    import rxs_pkg::*;
(
    input  logic              ext_clk,
    input  logic              lb_clk,
    input  logic              rst,
    input  logic              cfg_loop,
    input  logic              ext_data,
    input  logic              ext_start,
    input  logic              lb_data,
    input  logic              lb_fs,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_words,
    input  logic [SYNC_W-1:0] cfg_sync_len,
    input  logic              cfg_msb_first,
    output logic [DW-1:0]     word_data,
    output logic              word_valid,
    output logic              frame_done,
    output logic              busy,
    output logic              sync_out,
    output logic              cfg_error,
    output logic [1:0]        xfer_size
);
    logic       rx_clk;
    logic       rx_data;
    logic       rx_start;
    logic       accept;
    frame_cfg_t cfg_live;
    xfer_e      xs;

    assign cfg_live = '{len: cfg_len, words: cfg_words, msb: cfg_msb_first};
    assign xs        = xfer_of(cfg_len);
    assign xfer_size = xs;

    rxs_src_sel u_sel (
        .cfg_loop  (cfg_loop),
        .ext_clk   (ext_clk),
        .lb_clk    (lb_clk),
        .ext_data  (ext_data),
        .lb_data   (lb_data),
        .ext_start (ext_start),
        .lb_fs     (lb_fs),
        .rx_clk    (rx_clk),
        .rx_data   (rx_data),
        .rx_start  (rx_start)
    );

    rxs_deser #(.DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_deser (
        .clk        (rx_clk),
        .rst        (rst),
        .din        (rx_data),
        .start      (rx_start),
        .cfg_in     (cfg_live),
        .word_data  (word_data),
        .word_valid (word_valid),
        .frame_done (frame_done),
        .busy       (busy),
        .cfg_error  (cfg_error),
        .accept     (accept)
    );

    rxs_sync_gen #(.SYNC_W(SYNC_W)) u_sync (
        .clk      (rx_clk),
        .rst      (rst),
        .trig     (accept),
        .sync_len (cfg_sync_len),
        .sync_out (sync_out)
    );

    // R8
    xfer_zero_chk: assert property (@(posedge rx_clk) disable iff (rst)
        (cfg_len == '0) == (xfer_size == 2'd0));

    // R4
    done_busy_chk: assert property (@(posedge rx_clk) disable iff (rst)
        frame_done |-> !busy);
endmodule

// File: tb/rxs_frame_rx_bench.sv
module rxs_frame_rx_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_loop, ext_data, ext_start, lb_data, lb_fs, cfg_msb_first;
    logic [4:0]  cfg_len;
    logic [3:0]  cfg_words, cfg_sync_len;
    logic [31:0] word_data;
    logic        word_valid, frame_done, busy, sync_out, cfg_error;
    logic [1:0]  xfer_size;

    always #4 clk = ~clk;

    rxs_frame_rx u_rxs_frame_rx (
        .ext_clk(clk), .lb_clk(clk), .rst(rst), .cfg_loop(cfg_loop),
        .ext_data(ext_data), .ext_start(ext_start), .lb_data(lb_data), .lb_fs(lb_fs),
        .cfg_len(cfg_len), .cfg_words(cfg_words), .cfg_sync_len(cfg_sync_len),
        .cfg_msb_first(cfg_msb_first), .word_data(word_data), .word_valid(word_valid),
        .frame_done(frame_done), .busy(busy), .sync_out(sync_out),
        .cfg_error(cfg_error), .xfer_size(xfer_size)
    );

    typedef struct {
        logic [31:0] d;
        bit          last;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // monitor: compare each produced word against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R1 unexpected word", word_data, 32'h0);
            end else begin
                e = q.pop_front();
                chk(word_data == e.d, {e.tag, " word"}, word_data, e.d);
                chk(frame_done == e.last, "R4 frame_done", {31'd0, frame_done}, {31'd0, e.last});
            end
        end else if (!rst && frame_done) begin
            chk(1'b0, "R4 frame_done without word", 32'h1, 32'h0);
        end
    end

    task automatic drive_bit(input bit lp, input bit b, input bit st);
        if (lp) begin
            lb_data = b; ext_data = ~b; lb_fs = st; ext_start = ~st;
        end else begin
            ext_data = b; lb_data = ~b; ext_start = st; lb_fs = ~st;
        end
    endtask

    // driver: one frame, pushes expected words before sending their bits
    task automatic run_frame(input int len, input int nw, input int sl, input bit msb,
                             input bit lp, input int intr, input string tag);
        int total;
        int fs_hi;
        int bitno;
        logic [31:0] mask;
        logic [31:0] v;
        @(negedge clk);
        cfg_len = 5'(len); cfg_words = 4'(nw); cfg_sync_len = 4'(sl);
        cfg_msb_first = msb; cfg_loop = lp;
        drive_bit(lp, 1'b0, 1'b1);
        @(negedge clk);
        chk(cfg_error == 1'b0, "R6 error cleared", {31'd0, cfg_error}, 32'h0);
        total = (len + 1) * (nw + 1);
        fs_hi = 0;
        bitno = 0;
        mask  = (len == 31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 32'd1);
        for (int w = 0; w <= nw; w++) begin
            v = $urandom() & mask;
            q.push_back('{d: v, last: (w == nw), tag: tag});
            for (int i = 0; i <= len; i++) begin
                drive_bit(lp, msb ? v[len - i] : v[i], bitno == intr);
                if (sync_out) fs_hi++;
                bitno++;
                @(negedge clk);
            end
        end
        drive_bit(lp, 1'b0, 1'b0);
        if (total > sl + 1)
            chk(fs_hi == sl + 1, "R5 sync length", 32'(fs_hi), 32'(sl + 1));
        chk(busy == 1'b0, "R4 idle after frame", {31'd0, busy}, 32'h0);
        @(negedge clk);
        chk(q.size() == 0, "R1 all words seen", 32'(q.size()), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1'b1; cfg_loop = 1'b0; ext_data = 1'b0; ext_start = 1'b0;
        lb_data = 1'b0; lb_fs = 1'b0; cfg_len = 5'd7; cfg_words = 4'd0;
        cfg_sync_len = 4'd0; cfg_msb_first = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({word_valid, frame_done, busy, sync_out, cfg_error} == 5'b0, "R10 reset outputs",
            {27'd0, word_valid, frame_done, busy, sync_out, cfg_error}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 transfer size over every length
        for (int l = 0; l < 32; l++) begin
            logic [1:0] xe;
            cfg_len = 5'(l);
            #1;
            xe = (l == 0) ? 2'd0 : (l < 8) ? 2'd1 : (l < 16) ? 2'd2 : 2'd3;
            chk(xfer_size == xe, "R8 xfer_size", {30'd0, xfer_size}, {30'd0, xe});
        end

        // R2 / R3 single words of both orders
        run_frame(7, 0, 0, 1'b1, 1'b0, -1, "R2");
        run_frame(7, 0, 0, 1'b0, 1'b0, -1, "R3");
        // full width, several words, sync length 4
        run_frame(31, 1, 3, 1'b1, 1'b0, -1, "R2");
        // shortest word, long frame, longest sync
        run_frame(1, 3, 15, 1'b0, 1'b0, -1, "R3");
        run_frame(2, 15, 6, 1'b1, 1'b0, -1, "R1");

        // R6 zero length start refused
        @(negedge clk);
        cfg_len = 5'd0; cfg_loop = 1'b0; ext_start = 1'b1;
        @(negedge clk);
        ext_start = 1'b0;
        chk(cfg_error == 1'b1, "R6 cfg_error set", {31'd0, cfg_error}, 32'h1);
        chk(busy == 1'b0, "R6 no reception", {31'd0, busy}, 32'h0);
        chk(sync_out == 1'b0, "R6 no sync", {31'd0, sync_out}, 32'h0);
        repeat (5) @(negedge clk);
        chk(cfg_error == 1'b1, "R6 error holds", {31'd0, cfg_error}, 32'h1);

        // R7 start mid-frame and on the last bit of a word
        run_frame(15, 2, 15, 1'b1, 1'b0, 5, "R7");
        run_frame(3, 2, 2, 1'b0, 1'b0, 3, "R7");
        run_frame(3, 1, 1, 1'b1, 1'b0, 7, "R7");

        // R9 loopback with external pins complemented
        run_frame(11, 1, 2, 1'b1, 1'b1, -1, "R9");
        run_frame(4, 2, 0, 1'b0, 1'b1, -1, "R9");
        // R9 back to external pins, loop pins complemented
        run_frame(9, 0, 1, 1'b0, 1'b0, -1, "R9");

        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R7 no restart", {31'd0, busy}, 32'h0);
        done = 1;
        summary();
    end
endmodule